// File: doc/BRIEF.md
# Two-Level Composite-Field Constant Multiplier

This block multiplies an element of GF(2^(P·Q)) by a fixed weight, with the element held in tower form. The operand is split into Q subcells of P bits. Each subcell carries one symbol of the base field GF(2^P), whose reduction polynomial is a parameter. The weight is a Q×Q matrix of base-field constants, also given as a parameter. Output subcell k is the base-field sum, over j, of weight entry (k, j) times input subcell j.

The product is built in layers. In the inner layer, each base-field constant is a P×P binary matrix made of AND and XOR terms. In the middle layer, the Q partial products of one output subcell are XOR-combined. The outer layer is the arrangement of rows, which sets how subcells are wired to each other. The block is purely combinational. It is meant as the weight unit of one cell in a hierarchical cellular-automaton pattern generator. The same field size can be split in different ways, for example P=3, Q=2 or P=2, Q=3, just by changing the parameters.

Top module: `hcm_mul`

## Requirements
- R1: Subcell j of the operand and of the product occupies bits [j·P+P-1 : j·P]. Within a subcell, bit i is the coefficient of α^i. Weight entry (k, j) sits in WEIGHT bits [(k·Q+j)·P+P-1 : (k·Q+j)·P].
- R2: Output subcell k equals the XOR over j of W(k,j)·x_j. The product of two symbols is polynomial multiplication modulo x^P + POLY, where POLY holds the low P coefficients.
- R3: A zero weight entry (k, j) contributes nothing: output subcell k does not change when only input subcell j changes.
- R4: A weight entry equal to 1 passes its input subcell to the output unchanged.
- R5: An all-zero operand gives an all-zero product.
- R6: The map is linear over GF(2): f(a XOR b) = f(a) XOR f(b).
- R7: A second partition of the same 64-element field (P=2, Q=3, polynomial x^2+x+1) meets R2 for every operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | Q·P | Operand in tower form, Q subcells of P bits |
| prod_o | output | Q·P | Product of the operand and the constant weight matrix |

## Verification
A wrong inner constant matrix corrupts exactly one partial product. It therefore shows up in one output subcell, and only for operands whose input subcell j is non-zero. A wrong row combiner or a swapped subcell mapping shows up as a column mismatch against the flat binary reference. Because the block is combinational, any such fault is visible on prod_o in the same cycle the operand is applied. The exhaustive sweeps expose it within one pass over the 2^(P·Q) operands.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
  localparam int unsigned MAX_P = 16;
  typedef logic [MAX_P-1:0] sym_t;

  // multiply a symbol by alpha, reducing with x^p + poly
  function automatic sym_t sym_xtime(sym_t a, sym_t poly, int unsigned p);
    sym_t mask;
    sym_t r;
    logic top;
    mask = (sym_t'(1) << p) - sym_t'(1);
    top  = a[p-1];
    r    = (a << 1) & mask;
    if (top) r = r ^ (poly & mask);
    return r;
  endfunction

  function automatic sym_t sym_mul(sym_t a, sym_t b, sym_t poly, int unsigned p);
    sym_t acc;
    sym_t t;
    acc = '0;
    t   = a;
    for (int unsigned i = 0; i < MAX_P; i++) begin
      if (i < p) begin
        if (b[i]) acc = acc ^ t;
        t = sym_xtime(t, poly, p);
      end
    end
    return acc;
  endfunction

  // column c of the binary matrix of constant w is w * alpha^c
  function automatic logic [MAX_P*MAX_P-1:0] const_matrix(sym_t w, sym_t poly,
                                                          int unsigned p);
    logic [MAX_P*MAX_P-1:0] m;
    sym_t col;
    m   = '0;
    col = w;
    for (int unsigned c = 0; c < MAX_P; c++) begin
      if (c < p) begin
        m[c*MAX_P +: MAX_P] = col;
        col = sym_xtime(col, poly, p);
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/hcm_const_mat.sv
module hcm_const_mat #(
  parameter int unsigned P = 3,
  parameter logic [P-1:0] POLY = 3'b011,
  parameter logic [P-1:0] C = 3'b010
) (
  input  logic [P-1:0] x_i,
  output logic [P-1:0] y_o
);
  import hcm_pkg::*;
  localparam logic [MAX_P*MAX_P-1:0] MAT =
    const_matrix(sym_t'(C), sym_t'(POLY), P);

  // inner layer: each output bit is the XOR of the input bits in its row
  for (genvar r = 0; r < P; r++) begin : g_row
    logic [P-1:0] sel;
    for (genvar c = 0; c < P; c++) begin : g_col
      assign sel[c] = MAT[c*MAX_P + r] & x_i[c];
    end
    assign y_o[r] = ^sel;
  end
endmodule

// File: rtl/hcm_row.sv
module hcm_row #(
  parameter int unsigned P = 3,
  parameter int unsigned Q = 2,
  parameter logic [P-1:0] POLY = 3'b011,
  parameter logic [Q*P-1:0] ROW_W = '0
) (
  input  logic [Q*P-1:0] x_i,
  output logic [Q*P-1:0] terms_o,
  output logic [P-1:0]   y_o
);
  logic [(Q+1)*P-1:0] chain;
  assign chain[P-1:0] = '0;

  for (genvar j = 0; j < Q; j++) begin : g_ent
    hcm_const_mat #(.P(P), .POLY(POLY), .C(ROW_W[j*P +: P])) u_ent (
      .x_i(x_i[j*P +: P]),
      .y_o(terms_o[j*P +: P])
    );
    // middle layer: combine partial products of this subcell
    assign chain[(j+1)*P +: P] = chain[j*P +: P] ^ terms_o[j*P +: P];
  end

  assign y_o = chain[Q*P +: P];
endmodule

// File: rtl/hcm_mul.sv
module hcm_mul #(
  parameter int unsigned P = 3,
  parameter int unsigned Q = 2,
  parameter logic [P-1:0] POLY = 3'b011,
  parameter logic [Q*Q*P-1:0] WEIGHT = 12'b101_001_000_010
) (
  input  logic [Q*P-1:0] opnd_i,
  output logic [Q*P-1:0] prod_o
);
  localparam int unsigned ROWB = Q*P;

  // partial products, entry (k,j) at [(k*Q+j)*P +: P]
  logic [Q*Q*P-1:0] term_w;

  // outer layer: one row per output subcell
  for (genvar k = 0; k < Q; k++) begin : g_out
    hcm_row #(.P(P), .Q(Q), .POLY(POLY),
              .ROW_W(WEIGHT[k*ROWB +: ROWB])) u_row (
      .x_i(opnd_i),
      .terms_o(term_w[k*ROWB +: ROWB]),
      .y_o(prod_o[k*P +: P])
    );
  end
endmodule

// File: rtl/hcm_mul_chk.sv
module hcm_mul_chk #(
  parameter int unsigned P = 3,
  parameter int unsigned Q = 2,
  parameter logic [P-1:0] POLY = 3'b011,
  parameter logic [Q*Q*P-1:0] WEIGHT = 12'b101_001_000_010
) (
  input logic [Q*P-1:0]   opnd,
  input logic [Q*P-1:0]   prod,
  input logic [Q*Q*P-1:0] terms
);
  import hcm_pkg::*;

  always_comb begin
    for (int k = 0; k < Q; k++) begin
      for (int j = 0; j < Q; j++) begin
        // R3: zero entry yields an empty partial product
        if (WEIGHT[(k*Q+j)*P +: P] == '0)
          a_r3_zero_entry: assert (terms[(k*Q+j)*P +: P] == '0);
        // R4: unit entry forwards the subcell
        if (WEIGHT[(k*Q+j)*P +: P] == P'(1))
          a_r4_unit_entry: assert (terms[(k*Q+j)*P +: P] == opnd[j*P +: P]);
        // R2: binary-matrix term agrees with the shift-and-add product
        a_r2_term_product: assert (terms[(k*Q+j)*P +: P] ==
          P'(sym_mul(sym_t'(WEIGHT[(k*Q+j)*P +: P]), sym_t'(opnd[j*P +: P]),
                     sym_t'(POLY), P)));
      end
    end
    // R5: zero operand gives zero product
    if (opnd == '0) a_r5_zero_operand: assert (prod == '0);
  end
endmodule

bind hcm_mul hcm_mul_chk #(.P(P), .Q(Q), .POLY(POLY), .WEIGHT(WEIGHT)) u_chk (
  .opnd(opnd_i),
  .prod(prod_o),
  .terms(term_w)
);

// File: tb/tb_hcm_mul.sv
module tb_hcm_mul;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  // configuration A: P=3, Q=2, x^3+x+1, entries (0,0)=2 (0,1)=0 (1,0)=1 (1,1)=5
  localparam logic [11:0] WA = 12'b101_001_000_010;
  // configuration B: P=2, Q=3, x^2+x+1
  localparam logic [17:0] WB = {2'd1, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd2};

  logic [5:0] a_in, a_out, b_in, b_out;
  int vectors = 0;
  int fails   = 0;

  hcm_mul #(.P(3), .Q(2), .POLY(3'b011), .WEIGHT(WA)) dut (.opnd_i(a_in), .prod_o(a_out));
  hcm_mul #(.P(2), .Q(3), .POLY(2'b11), .WEIGHT(WB)) dut2 (.opnd_i(b_in), .prod_o(b_out));

  // bench multiply: table of alpha powers, then exponent addition
  function automatic int pow_elem(int e, int p, int poly);
    int v = 1;
    for (int i = 0; i < e; i++) begin
      v = v << 1;
      if (v >> p != 0) v = (v ^ (1 << p) ^ poly);
    end
    return v;
  endfunction

  function automatic int bmul(int a, int b, int p, int poly);
    int acc = 0;
    for (int i = 0; i < p; i++)
      for (int m = 0; m < p; m++)
        if (a[i] && b[m]) acc ^= pow_elem(i + m, p, poly);
    return acc;
  endfunction

  // flat (pq)x(pq) binary matrix: column for unit input bit, then XOR of columns
  function automatic int flat_ref(int x, int p, int q, int poly, logic [17:0] w);
    int res = 0;
    for (int bpos = 0; bpos < p*q; bpos++) begin
      if (x[bpos]) begin
        int j = bpos / p;
        int col = 0;
        for (int k = 0; k < q; k++) begin
          int we = (w >> ((k*q + j)*p)) & ((1 << p) - 1);
          col |= bmul(we, 1 << (bpos % p), p, poly) << (k*p);
        end
        res ^= col;
      end
    end
    return res;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_a(int v);
    @(negedge clk);
    a_in = 6'(v);
    #1;
  endtask

  task automatic apply_b(int v);
    @(negedge clk);
    b_in = 6'(v);
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int sub0;
    int fa;
    int fb;
    a_in = '0;
    b_in = '0;
    // R5: zero operand
    apply_a(0); check("R5", int'(a_out), 0);
    apply_b(0); check("R5", int'(b_out), 0);
    // R1 R2: exhaustive sweep, configuration A
    for (int v = 0; v < 64; v++) begin
      apply_a(v);
      check("R2", int'(a_out), flat_ref(v, 3, 2, 3, 18'(WA)));
    end
    // R1 R7: exhaustive sweep, configuration B
    for (int v = 0; v < 64; v++) begin
      apply_b(v);
      check("R7", int'(b_out), flat_ref(v, 2, 3, 3, WB));
    end
    // R3: entry (0,1) is zero, so output subcell 0 ignores input subcell 1
    for (int v = 0; v < 8; v++) begin
      apply_a(v);
      sub0 = int'(a_out[2:0]);
      for (int h = 1; h < 8; h++) begin
        apply_a((h << 3) | v);
        check("R3", int'(a_out[2:0]), sub0);
      end
    end
    // R4: entry (1,0) is 1; with input subcell 1 zero, output subcell 1 equals subcell 0
    for (int v = 0; v < 8; v++) begin
      apply_a(v);
      check("R4", int'(a_out[5:3]), v);
    end
    // R6: linearity on pairs, configuration B
    for (int a = 0; a < 64; a += 7) begin
      for (int b = 1; b < 64; b += 11) begin
        apply_b(a); fa = int'(b_out);
        apply_b(b); fb = int'(b_out);
        apply_b(a ^ b);
        check("R6", int'(b_out), fa ^ fb);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule